// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Detector with Lock Qualification

This block holds the digital phase-frequency detectors of a two-channel frequency synthesizer. Each channel sees a divided reference pulse train and a divided feedback pulse train, both synchronous to the reference-oscillator clock. A rising edge on either input sets a pump request flop. When both flops are set, a short overlap follows and then both are cleared, so the analog pump always sees a brief pulse, even with no phase error. A per-channel polarity bit decides which request drives the pump high and which drives it low. When neither drives, the pump output floats.

Each channel also has a lock qualifier. It measures how many oscillator cycles a one-sided error pulse lasts. A long error drops lock at once. Lock is restored only after a run of consecutive short comparisons. A per-channel sleep input silences the pump, clears the channel state and reports the channel as locked. After sleep or reset, feedback edges are ignored until a reference edge re-arms the comparison.

A shared pin multiplexer outputs either the combined lock flag of both channels or one of four raw divider signals for bench monitoring.

Top module: `dual_pfd_lock`

## Requirements
- R1: After reset, with sleep inputs low, every pump drive, enable, channel lock, combined lock and the multiplexed pin read 0.
- R2: With polarity 1, a reference edge leading a feedback edge by w cycles raises drv_hi (and drv_en) for w cycles, starting the cycle after the reference edge is sampled. drv_lo stays low during those cycles.
- R3: With polarity 0, the same leading request appears on drv_lo instead of drv_hi.
- R4: Once both requests are set, drv_hi, drv_lo and drv_en are all high for exactly OVL_CYC (default 2) cycles, after which all three drop. This includes zero phase error (both edges in the same cycle).
- R5: After reset or after sleep is released, feedback edges produce no drive until a reference edge has been seen.
- R6: When a one-sided error pulse reaches UNLOCK_CYC (default 4) cycles, the channel lock flag drops in that same cycle. The comparison then counts as bad.
- R7: A comparison whose error width is below UNLOCK_CYC counts as good. The lock flag rises one cycle after both requests are set, on the QUAL_CNT-th (default 3) consecutive good comparison.
- R8: While a channel's sleep input is high, its pump drive and enable read 0 and its lock flag reads 1 in the same cycle. Lock qualification restarts from zero once sleep is released.
- R9: The combined lock flag is the AND of both channels' lock flags.
- R10: With lds_i low the pin carries the combined lock flag. With lds_i high it carries a raw divider input chosen by mon_sel_i: bit 0 picks the channel (0 low band = channel 0, 1 high band = channel 1) and bit 1 picks the signal (0 reference, 1 feedback).
- R11: Further edges on the leading input while its request is already set are absorbed. The request stays high until the lagging edge arrives, and the overlap then clears both requests as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in_i | input | 2 | Divided reference pulse per channel |
| fb_in_i | input | 2 | Divided feedback pulse per channel |
| pol_i | input | 2 | Per-channel pump polarity |
| sleep_i | input | 2 | Per-channel power-save, active high |
| lds_i | input | 1 | Pin select: 0 lock flag, 1 monitor signal |
| mon_sel_i | input | 2 | Monitor source (bit 0 channel, bit 1 ref/feedback) |
| drv_hi_o | output | 2 | Pump drive-high enable per channel |
| drv_lo_o | output | 2 | Pump drive-low enable per channel |
| drv_en_o | output | 2 | Pump output enable; 0 means high impedance |
| chan_lock_o | output | 2 | Per-channel lock flag |
| lock_all_o | output | 1 | Combined lock flag |
| mux_o | output | 1 | Multiplexed lock/monitor pin |

## Verification
Results fall into two timing classes.

Some outputs follow their inputs combinationally and are due in the same cycle as the stimulus: the sleep gating, the combined lock and the multiplexed pin.

The pump requests are one register behind. A request shows in the cycle after the edge is sampled. For a lead of w cycles, the overlap occupies cycles w+1 and w+2 after the leading edge, and everything is idle at w+3. The lock update shows at w+2, and an unlock shows five cycles after the leading edge.

The driver stamps every expected item with the absolute cycle number derived from these counts. The monitor compares items at the falling clock edge of exactly that cycle. Any item left over at the end counts as a failure.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int NCH = 2;
    localparam int MSW = 1 + $clog2(NCH);

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } drive_t;

    typedef enum logic {
        SRC_REF = 1'b0,
        SRC_FB  = 1'b1
    } mon_kind_e;

    function automatic drive_t steer(pump_t p, logic pol);
        drive_t d;
        d.hi = pol ? p.up : p.dn;
        d.lo = pol ? p.dn : p.up;
        return d;
    endfunction

endpackage

// File: rtl/pfd_phase_cmp.sv
module pfd_phase_cmp
    import pfd_pkg::*;
#(
    parameter int OVL_CYC = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sleep,
    input  logic  ref_in,
    input  logic  fb_in,
    output pump_t pump_o,
    output logic  cmp_done_o
);
    localparam int OW = $clog2(OVL_CYC + 1);

    logic          ref_d, fb_d, armed;
    logic [OW-1:0] ovl_cnt;
    pump_t         pump_q;
    logic          ref_edge, fb_edge;

    assign ref_edge = ref_in & ~ref_d;
    assign fb_edge  = fb_in & ~fb_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_d <= 1'b0;
            fb_d  <= 1'b0;
        end else begin
            ref_d <= ref_in;
            fb_d  <= fb_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sleep) begin
            pump_q  <= '0;
            armed   <= 1'b0;
            ovl_cnt <= '0;
        end else if (pump_q.up && pump_q.dn) begin
            if (int'(ovl_cnt) == OVL_CYC - 1) begin
                pump_q.up <= ref_edge;
                pump_q.dn <= fb_edge;
                ovl_cnt   <= '0;
            end else begin
                ovl_cnt <= ovl_cnt + 1'b1;
            end
        end else begin
            if (ref_edge) begin
                armed     <= 1'b1;
                pump_q.up <= 1'b1;
            end
            if (fb_edge && (armed || ref_edge)) begin
                pump_q.dn <= 1'b1;
            end
        end
    end

    assign pump_o     = pump_q;
    assign cmp_done_o = pump_q.up & pump_q.dn & (ovl_cnt == '0);

endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual
    import pfd_pkg::*;
#(
    parameter int UNLOCK_CYC = 4,
    parameter int QUAL_CNT   = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sleep,
    input  pump_t pump,
    input  logic  cmp_done,
    output logic  lock_o
);
    localparam int EW = $clog2(UNLOCK_CYC + 1);
    localparam int QW = $clog2(QUAL_CNT + 1);

    logic [EW-1:0] err_cnt;
    logic [QW-1:0] good_cnt;
    logic          locked;

    always_ff @(posedge clk) begin
        if (rst || sleep) begin
            err_cnt  <= '0;
            good_cnt <= '0;
            locked   <= 1'b0;
        end else if (cmp_done) begin
            err_cnt <= '0;
            if (int'(err_cnt) < UNLOCK_CYC) begin
                if (int'(good_cnt) < QUAL_CNT) good_cnt <= good_cnt + 1'b1;
                if (int'(good_cnt) >= QUAL_CNT - 1) locked <= 1'b1;
            end else begin
                good_cnt <= '0;
                locked   <= 1'b0;
            end
        end else if (pump.up ^ pump.dn) begin
            if (int'(err_cnt) < UNLOCK_CYC) err_cnt <= err_cnt + 1'b1;
            if (int'(err_cnt) == UNLOCK_CYC - 1) begin
                locked   <= 1'b0;
                good_cnt <= '0;
            end
        end
    end

    assign lock_o = locked;

endmodule

// File: rtl/pfd_out_mux.sv
module pfd_out_mux
    import pfd_pkg::*;
(
    input  logic [NCH-1:0] chan_lock,
    input  logic [NCH-1:0] ref_in,
    input  logic [NCH-1:0] fb_in,
    input  logic           lds,
    input  logic [MSW-1:0] mon_sel,
    output logic           lock_all,
    output logic           pin_o
);
    mon_kind_e             kind;
    logic [MSW-2:0]        idx;
    logic                  mon_val;

    assign lock_all = &chan_lock;
    assign kind     = mon_kind_e'(mon_sel[MSW-1]);
    assign idx      = mon_sel[MSW-2:0];

    always_comb begin
        case (kind)
            SRC_REF: mon_val = ref_in[idx];
            SRC_FB:  mon_val = fb_in[idx];
            default: mon_val = 1'b0;
        endcase
    end

    assign pin_o = lds ? mon_val : lock_all;

endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
    import pfd_pkg::*;
#(
    parameter int OVL_CYC    = 2,
    parameter int UNLOCK_CYC = 4,
    parameter int QUAL_CNT   = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] ref_in_i,
    input  logic [NCH-1:0] fb_in_i,
    input  logic [NCH-1:0] pol_i,
    input  logic [NCH-1:0] sleep_i,
    input  logic           lds_i,
    input  logic [MSW-1:0] mon_sel_i,
    output logic [NCH-1:0] drv_hi_o,
    output logic [NCH-1:0] drv_lo_o,
    output logic [NCH-1:0] drv_en_o,
    output logic [NCH-1:0] chan_lock_o,
    output logic           lock_all_o,
    output logic           mux_o
);
    logic [NCH-1:0] lock_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pump_t  pump;
        logic   cmp_done;
        drive_t drv;

        pfd_phase_cmp #(.OVL_CYC(OVL_CYC)) u_cmp (
            .clk        (clk),
            .rst        (rst),
            .sleep      (sleep_i[c]),
            .ref_in     (ref_in_i[c]),
            .fb_in      (fb_in_i[c]),
            .pump_o     (pump),
            .cmp_done_o (cmp_done)
        );

        pfd_lock_qual #(.UNLOCK_CYC(UNLOCK_CYC), .QUAL_CNT(QUAL_CNT)) u_lock (
            .clk      (clk),
            .rst      (rst),
            .sleep    (sleep_i[c]),
            .pump     (pump),
            .cmp_done (cmp_done),
            .lock_o   (lock_q[c])
        );

        assign drv            = steer(pump, pol_i[c]);
        assign drv_hi_o[c]    = drv.hi & ~sleep_i[c];
        assign drv_lo_o[c]    = drv.lo & ~sleep_i[c];
        assign drv_en_o[c]    = (drv.hi | drv.lo) & ~sleep_i[c];
        assign chan_lock_o[c] = lock_q[c] | sleep_i[c];
    end

    pfd_out_mux u_mux (
        .chan_lock (chan_lock_o),
        .ref_in    (ref_in_i),
        .fb_in     (fb_in_i),
        .lds       (lds_i),
        .mon_sel   (mon_sel_i),
        .lock_all  (lock_all_o),
        .pin_o     (mux_o)
    );

endmodule

// File: rtl/dual_pfd_lock_chk.sv
module dual_pfd_lock_chk
    import pfd_pkg::*;
#(
    parameter int UNLOCK_CYC = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] sleep_i,
    input logic [NCH-1:0] drv_hi_o,
    input logic [NCH-1:0] drv_lo_o,
    input logic [NCH-1:0] drv_en_o,
    input logic [NCH-1:0] chan_lock_o
);
    localparam int EW = $clog2(UNLOCK_CYC + 1);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic [EW-1:0] run;

        always_ff @(posedge clk) begin
            if (rst || sleep_i[c] || !(drv_hi_o[c] ^ drv_lo_o[c])) run <= '0;
            else if (int'(run) < UNLOCK_CYC) run <= run + 1'b1;
        end

        AST_OVERLAP_BOUND: assert property (@(posedge clk) disable iff (rst)
            (drv_hi_o[c] && drv_lo_o[c] && $past(drv_hi_o[c] && drv_lo_o[c])) |=> !(drv_hi_o[c] && drv_lo_o[c])); // R4
        AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
            sleep_i[c] |-> (!drv_en_o[c] && chan_lock_o[c])); // R8
        AST_UNLOCK_WIDTH: assert property (@(posedge clk) disable iff (rst)
            (int'(run) >= UNLOCK_CYC && !sleep_i[c]) |-> !chan_lock_o[c]); // R6
        AST_LOCK_AT_OVERLAP: assert property (@(posedge clk) disable iff (rst)
            ($rose(chan_lock_o[c]) && !sleep_i[c]) |-> $past(drv_hi_o[c] && drv_lo_o[c])); // R7
    end

endmodule

bind dual_pfd_lock dual_pfd_lock_chk #(.UNLOCK_CYC(UNLOCK_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sleep_i     (sleep_i),
    .drv_hi_o    (drv_hi_o),
    .drv_lo_o    (drv_lo_o),
    .drv_en_o    (drv_en_o),
    .chan_lock_o (chan_lock_o)
);

// File: tb/dual_pfd_lock_tb.sv
module dual_pfd_lock_tb;
    import pfd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [1:0] ref_i = '0, fb_i = '0, pol_i = '0, sleep_i = '0, mon_sel_i = '0;
    logic       lds_i = 1'b0;
    logic [1:0] drv_hi, drv_lo, drv_en, chan_lock;
    logic       lock_all, mux_o;

    dual_pfd_lock u_dut (
        .clk(clk), .rst(rst), .ref_in_i(ref_i), .fb_in_i(fb_i), .pol_i(pol_i),
        .sleep_i(sleep_i), .lds_i(lds_i), .mon_sel_i(mon_sel_i),
        .drv_hi_o(drv_hi), .drv_lo_o(drv_lo), .drv_en_o(drv_en),
        .chan_lock_o(chan_lock), .lock_all_o(lock_all), .mux_o(mux_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [9:0] mask;
        logic [9:0] val;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;
    int   good[2];
    logic lk[2];

    wire [9:0] obs = {mux_o, lock_all, chan_lock, drv_en, drv_lo, drv_hi};

    // monitor: compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                n_chk++;
                if ((obs & sb[i].mask) !== (sb[i].val & sb[i].mask)) begin
                    n_err++;
                    $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                             sb[i].req, cyc, obs & sb[i].mask, sb[i].val & sb[i].mask, sb[i].mask);
                end
                sb.delete(i);
            end
        end
    end

    task automatic push(int at, logic [9:0] m, logic [9:0] v, string r);
        exp_t e;
        e.at = at; e.mask = m; e.val = v; e.req = r;
        sb.push_back(e);
    endtask

    task automatic adv();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [9:0] dbits(int ch, logic hi, logic lo, logic en);
        logic [9:0] b = '0;
        b[ch] = hi; b[2+ch] = lo; b[4+ch] = en;
        return b;
    endfunction

    function automatic logic [9:0] lbits(int ch, logic l, logic all);
        logic [9:0] b = '0;
        b[6+ch] = l; b[8] = all; b[9] = all;
        return b;
    endfunction

    function automatic logic other_lock(int ch);
        return sleep_i[1-ch] | lk[1-ch];
    endfunction

    // one comparison: leading edge at cycle s, lagging edge w cycles later
    task automatic compare(int ch, bit ref_first, int w, bit pol, bit extra, string r);
        int   s;
        logic lead_hi, nl;
        logic [9:0] dm, lm;
        pol_i[ch] = pol;
        adv();
        s = cyc;
        lead_hi = pol ? ref_first : !ref_first;
        dm = dbits(ch, 1, 1, 1);
        lm = lbits(ch, 1, 1);
        for (int i = 1; i <= w; i++)
            push(s + i, dm, dbits(ch, lead_hi, !lead_hi, 1), r);
        push(s + w + 1, dm, dbits(ch, 1, 1, 1), "R4");
        push(s + w + 2, dm, dbits(ch, 1, 1, 1), "R4");
        push(s + w + 3, dm, dbits(ch, 0, 0, 0), "R4");
        if (w >= 4) begin
            lk[ch] = 1'b0; good[ch] = 0;
            push(s + 5, lm, lbits(ch, 0, 0), "R6");
            push(s + w + 2, lm, lbits(ch, 0, 0), "R6");
        end else begin
            push(s + w + 1, lm, lbits(ch, lk[ch], lk[ch] & other_lock(ch)), "R7");
            if (good[ch] < 3) good[ch]++;
            if (good[ch] >= 3) lk[ch] = 1'b1;
            nl = lk[ch];
            push(s + w + 2, lm, lbits(ch, nl, nl & other_lock(ch)), "R7/R9");
        end
        for (int i = 0; i <= w + 4; i++) begin
            logic ld, lg;
            ld = (i == 0) || (extra && i == 3);
            lg = (i == w);
            ref_i[ch] = ref_first ? ld : lg;
            fb_i[ch]  = ref_first ? lg : ld;
            adv();
        end
        ref_i[ch] = 1'b0;
        fb_i[ch]  = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            if (sb.size() != 0) begin
                n_chk++; n_err++;
                $display("FAIL pending=%0d items never compared (actual=%0d expected=0)", sb.size(), sb.size());
            end
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        int s;
        good[0] = 0; good[1] = 0; lk[0] = 1'b0; lk[1] = 1'b0;
        repeat (3) adv();
        rst = 1'b0;
        push(cyc, 10'h3FF, 10'h000, "R1");
        push(cyc + 1, 10'h3FF, 10'h000, "R1");
        adv(); adv();
        sleep_i[1] = 1'b1;
        adv();

        // R5: feedback before any reference edge is ignored
        s = cyc;
        fb_i[0] = 1'b1; adv(); fb_i[0] = 1'b0;
        push(s + 1, dbits(0, 1, 1, 1), 10'h000, "R5");
        push(s + 2, dbits(0, 1, 1, 1), 10'h000, "R5");
        adv(); adv(); adv();

        compare(0, 1, 3, 1, 0, "R2");   // reference leads
        compare(0, 1, 0, 1, 0, "R4");   // equal phase
        compare(0, 0, 2, 1, 0, "R2");   // feedback leads, lock reached
        compare(0, 1, 5, 0, 0, "R3");   // inverted polarity, unlock
        compare(0, 0, 1, 0, 0, "R3");
        compare(0, 1, 6, 1, 1, "R11");  // repeated leading edge absorbed

        // R8: sleep mid-pulse, then R5 after wake
        pol_i[0] = 1'b1;
        adv();
        s = cyc;
        ref_i[0] = 1'b1; adv(); ref_i[0] = 1'b0;
        push(s + 1, dbits(0, 1, 1, 1), dbits(0, 1, 0, 1), "R2");
        adv();
        sleep_i[0] = 1'b1;
        lk[0] = 1'b0; good[0] = 0;
        push(s + 2, dbits(0, 1, 1, 1) | lbits(0, 1, 1), dbits(0, 0, 0, 0) | lbits(0, 1, 1), "R8");
        adv(); adv(); adv();
        sleep_i[0] = 1'b0;
        push(s + 5, dbits(0, 1, 1, 1) | lbits(0, 1, 1), lbits(0, 0, 0), "R8");
        adv();
        fb_i[0] = 1'b1; adv(); fb_i[0] = 1'b0;
        push(s + 7, dbits(0, 1, 1, 1), 10'h000, "R5");
        push(s + 8, dbits(0, 1, 1, 1), 10'h000, "R5");
        adv(); adv();
        compare(0, 1, 1, 1, 0, "R5");

        // R10: monitor selection with both channels asleep
        sleep_i = 2'b11;
        adv(); adv();
        lds_i = 1'b1;
        ref_i = 2'b10;
        fb_i  = 2'b01;
        for (int sel = 0; sel < 4; sel++) begin
            logic [1:0] sv;
            logic [9:0] v;
            sv = 2'(sel);
            mon_sel_i = sv;
            v = '0;
            v[9] = sv[1] ? fb_i[sv[0]] : ref_i[sv[0]];
            push(cyc, 10'h200, v, "R10");
            adv();
        end
        lds_i = 1'b0;
        push(cyc, 10'h3C0, 10'h3C0, "R10/R9");
        adv();
        ref_i = '0; fb_i = '0;
        adv();
        sleep_i = 2'b01;
        push(cyc, 10'h3C0, 10'h040, "R9");
        adv(); adv(); adv();
        finish_up();
    end

endmodule